// File: doc/BRIEF.md
# Serial Command Framer and Register Decoder

This block takes 16-bit command words from a three-wire serial link made of a shift clock, an active-low frame enable and a data line. It turns each complete word into one register update. The three serial lines are brought into the system clock domain through synchronizers and are sampled there. Their edges are found from the sampled levels, so the shift clock must stay well below the system clock rate. While the enable is low, each rising shift-clock edge moves one data bit into a 16-bit shift register, most significant bit first. When the enable rises and exactly sixteen bits were taken, the low four bits act as an address and the upper twelve bits as the payload.

The block holds twelve 8-bit converter code registers. Channels 0 to 3 are dedicated analog outputs. Channels 4 to 11 share their pins with general-purpose I/O, and each of these has an analog-enable bit. The block also holds a 12-bit pin direction register and a 12-bit pin output register. One command copies the pin inputs into the shift register, and the next frame then reads them out on the serial output. That output always shows the last shift stage, so several devices can be chained. A special address-zero pattern turns off the analog drive of all shared channels at once.

Top module: `sdac_cmd_top`

## Requirements
- R1: After reset all twelve codes are 0, `ana_en` is 0, `pin_dir` and `pin_out` are 0, and `ser_dout_oe` is 0.
- R2: A data bit is taken on each rising `ser_clk` edge while `ser_en` is low. The first bit of a frame ends up in frame bit 15, and bits [3:0] form the address.
- R3: A frame is acted on only at the rising edge of `ser_en`, and only if exactly 16 clock edges were taken since `ser_en` fell. Frames of 15 or 17 edges change no register.
- R4: Address values 1 to 12 write frame bits [11:4] into code channel address-1. Frame bits [15:12] are ignored.
- R5: Address 14 loads `pin_dir` with frame bits [15:4], and address 15 loads `pin_out` with frame bits [15:4]. Pin k takes frame bit k+4.
- R6: Address 0 with frame bits [7:4] = 1101 clears every `ana_en` bit and leaves all codes unchanged, whatever bits [15:8] hold. Any other address-0 frame has no effect.
- R7: A code write to channel 4 to 11 sets `ana_en[channel-4]`. A write to channels 0 to 3 leaves `ana_en` unchanged.
- R8: Address 13 loads `pin_in[11:0]` into shift-register bits [15:4] and zeros into bits [3:0]. The next frame presents them on `ser_dout`, bit 15 first, one per clock edge.
- R9: `ser_dout` is shift-register bit 15, so during a 16-edge frame it replays the previous frame bit by bit. `ser_dout_oe` is high only while the synchronized `ser_en` is low.
- R10: A `ser_clk` rise sampled in the same cycle as a `ser_en` rise is not shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_en | input | 1 | Frame enable, active low |
| ser_din | input | 1 | Serial data in |
| pin_in | input | 12 | Levels read from the I/O pins |
| ser_dout | output | 1 | Serial data out (last shift stage) |
| ser_dout_oe | output | 1 | Drive enable for ser_dout |
| dac_code | output | 96 | Twelve 8-bit codes, channel n at [8n+7:8n] |
| ana_en | output | 8 | Analog enable of shared channels 4..11 |
| pin_dir | output | 12 | Pin direction, 1 = output |
| pin_out | output | 12 | Pin output data |

## Verification
The rising edge of `ser_en` that commits a frame can land in the same sampled cycle as a rising `ser_clk` edge. The bench provokes this by toggling both lines at one instant. In the first case this happens after sixteen normal edges, and the frame must still be accepted. In the second case the coincident edge would have been the sixteenth, so the frame must be thrown away with no register change. Both outcomes are judged from the register outputs and from the bits that `ser_dout` replays in the following frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 4;
    localparam int PAY_W   = FRAME_W - ADDR_W;
    localparam int CODE_W  = 8;
    localparam int NUM_CH  = 12;
    localparam int NUM_DED = 4;
    localparam int NUM_SHR = NUM_CH - NUM_DED;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [ADDR_W-1:0] A_SPECIAL = 4'd0;
    localparam logic [ADDR_W-1:0] A_DAC_LO  = 4'd1;
    localparam logic [ADDR_W-1:0] A_DAC_HI  = 4'd12;
    localparam logic [ADDR_W-1:0] A_CAPT    = 4'd13;
    localparam logic [ADDR_W-1:0] A_DIR     = 4'd14;
    localparam logic [ADDR_W-1:0] A_OUT     = 4'd15;
    localparam logic [ADDR_W-1:0] HIZ_KEY   = 4'b1101;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DAC,
        OP_HIZ,
        OP_CAPT,
        OP_DIR,
        OP_OUT
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [CH_W-1:0]    ch;
        logic [CODE_W-1:0]  code;
        logic [PAY_W-1:0]   payload;
    } cmd_t;

    function automatic cmd_t decode_frame(input logic [FRAME_W-1:0] f);
        cmd_t c;
        logic [ADDR_W-1:0] a;
        a         = f[ADDR_W-1:0];
        c.payload = f[FRAME_W-1:ADDR_W];
        c.code    = f[ADDR_W+CODE_W-1:ADDR_W];
        c.ch      = CH_W'(a - A_DAC_LO);
        if (a >= A_DAC_LO && a <= A_DAC_HI)
            c.op = OP_DAC;
        else if (a == A_CAPT)
            c.op = OP_CAPT;
        else if (a == A_DIR)
            c.op = OP_DIR;
        else if (a == A_OUT)
            c.op = OP_OUT;
        else if (a == A_SPECIAL && f[2*ADDR_W-1:ADDR_W] == HIZ_KEY)
            c.op = OP_HIZ;
        else
            c.op = OP_NONE;
        return c;
    endfunction

endpackage

// File: rtl/sdac_bit_sync.sv
module sdac_bit_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= RST_VAL;
                else if (s == 0)
                    stg[s] <= d;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_frame_shifter.sv
module sdac_frame_shifter
    import sdac_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int PW = PAY_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk_lvl,
    input  logic          en_lvl,
    input  logic          din_lvl,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic [FW-1:0] frame,
    output logic          commit,
    output logic          selected
);
    localparam logic [CW-1:0] CNT_FULL = CW'(FW);
    localparam logic [CW-1:0] CNT_SAT  = CW'(FW + 1);

    logic          sclk_d, en_d;
    logic          shift, start, en_rise;
    logic [CW-1:0] cnt;
    logic [FW-1:0] sr;

    assign shift   = sclk_lvl & ~sclk_d & ~en_lvl;
    assign start   = ~en_lvl & en_d;
    assign en_rise = en_lvl & ~en_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            en_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_lvl;
            en_d   <= en_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= shift ? CW'(1) : '0;
        else if (shift && cnt != CNT_SAT)
            cnt <= cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (load)
            sr <= {load_val, {(FW-PW){1'b0}}};
        else if (shift)
            sr <= {sr[FW-2:0], din_lvl};
    end

    assign frame    = sr;
    assign commit   = en_rise && (cnt == CNT_FULL);
    assign selected = ~en_lvl;

    AST_SHIFT_TAKES_BIT: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (sr[0] == $past(din_lvl))) else $error("shift bit"); // R2
    AST_COMMIT_EN_HIGH: assert property (@(posedge clk) disable iff (rst)
        commit |-> (en_lvl && !shift)) else $error("commit while selected"); // R10
endmodule

// File: rtl/sdac_reg_bank.sv
module sdac_reg_bank
    import sdac_pkg::*;
#(
    parameter int NCH  = NUM_CH,
    parameter int NDED = NUM_DED,
    parameter int NSHR = NUM_SHR,
    parameter int CDW  = CODE_W,
    parameter int PW   = PAY_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  cmd_t                     cmd,
    output logic [NCH-1:0][CDW-1:0]  codes,
    output logic [NSHR-1:0]          ana_en,
    output logic [PW-1:0]            pin_dir,
    output logic [PW-1:0]            pin_out
);
    logic wr_dac, wr_hiz;
    assign wr_dac = wr && (cmd.op == OP_DAC);
    assign wr_hiz = wr && (cmd.op == OP_HIZ);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_code
            always_ff @(posedge clk) begin
                if (rst)
                    codes[g] <= '0;
                else if (wr_dac && cmd.ch == CH_W'(g))
                    codes[g] <= cmd.code;
            end
        end
        for (genvar k = 0; k < NSHR; k++) begin : g_ana
            always_ff @(posedge clk) begin
                if (rst)
                    ana_en[k] <= 1'b0;
                else if (wr_hiz)
                    ana_en[k] <= 1'b0;
                else if (wr_dac && cmd.ch == CH_W'(NDED + k))
                    ana_en[k] <= 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_dir <= '0;
            pin_out <= '0;
        end else if (wr) begin
            if (cmd.op == OP_DIR) pin_dir <= cmd.payload;
            if (cmd.op == OP_OUT) pin_out <= cmd.payload;
        end
    end

    AST_HIZ_CLEARS_ANA: assert property (@(posedge clk) disable iff (rst)
        wr_hiz |=> (ana_en == '0)) else $error("hiz clear"); // R6
    AST_HIZ_KEEPS_CODES: assert property (@(posedge clk) disable iff (rst)
        wr_hiz |=> $stable(codes)) else $error("hiz touched codes"); // R6
    AST_ANA_SET_SRC: assert property (@(posedge clk) disable iff (rst)
        (|(ana_en & ~$past(ana_en))) |-> $past(wr_dac)) else $error("ana set"); // R7
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && cmd.op == OP_DIR) |=> $stable(pin_dir)) else $error("dir moved"); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && cmd.op == OP_OUT) |=> $stable(pin_out)) else $error("out moved"); // R5
endmodule

// File: rtl/sdac_cmd_top.sv
module sdac_cmd_top
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_clk,
    input  logic                     ser_en,
    input  logic                     ser_din,
    input  logic [PAY_W-1:0]         pin_in,
    output logic                     ser_dout,
    output logic                     ser_dout_oe,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_SHR-1:0]       ana_en,
    output logic [PAY_W-1:0]         pin_dir,
    output logic [PAY_W-1:0]         pin_out
);
    logic [2:0]                     sync_q;
    logic [FRAME_W-1:0]             frame;
    logic                           commit, selected;
    cmd_t                           cmd;
    logic [NUM_CH-1:0][CODE_W-1:0]  codes;

    sdac_bit_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_din, ser_en, ser_clk}),
        .q   (sync_q)
    );

    assign cmd = decode_frame(frame);

    sdac_frame_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_lvl (sync_q[0]),
        .en_lvl   (sync_q[1]),
        .din_lvl  (sync_q[2]),
        .load     (commit && cmd.op == OP_CAPT),
        .load_val (pin_in),
        .frame    (frame),
        .commit   (commit),
        .selected (selected)
    );

    sdac_reg_bank u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (commit),
        .cmd     (cmd),
        .codes   (codes),
        .ana_en  (ana_en),
        .pin_dir (pin_dir),
        .pin_out (pin_out)
    );

    assign dac_code    = codes;
    assign ser_dout    = frame[FRAME_W-1];
    assign ser_dout_oe = selected;

    AST_DED_NO_ANA: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd.op == OP_DAC && cmd.ch < CH_W'(NUM_DED)) |=> $stable(ana_en))
        else $error("dedicated write changed ana"); // R7
    AST_CODES_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(dac_code)) else $error("code moved"); // R3
endmodule

// File: tb/tb_sdac_cmd_top.sv
`timescale 1ns/1ps
module tb_sdac_cmd_top;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_en = 1'b1, ser_din = 1'b0;
    logic [11:0] pin_in = '0;
    logic        ser_dout, ser_dout_oe;
    logic [95:0] dac_code;
    logic [7:0]  ana_en;
    logic [11:0] pin_dir, pin_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  m_code [12];
    logic [7:0]  m_ana;
    logic [11:0] m_dir, m_out;
    logic [15:0] m_sr;

    always #2 clk = ~clk;

    sdac_cmd_top dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en(ser_en), .ser_din(ser_din),
        .pin_in(pin_in), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .dac_code(dac_code), .ana_en(ana_en), .pin_dir(pin_dir), .pin_out(pin_out)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [95:0] flat_codes();
        logic [95:0] v;
        for (int i = 0; i < 12; i++) v[i*8 +: 8] = m_code[i];
        return v;
    endfunction

    function automatic void apply_word(input logic [15:0] w);
        logic [3:0] a;
        a = w[3:0];
        if (a >= 4'd1 && a <= 4'd12) begin
            m_code[a-1] = w[11:4];
            if (a >= 4'd5) m_ana[a-5] = 1'b1;
        end else if (a == 4'd13) begin
            m_sr = {pin_in, 4'b0000};
        end else if (a == 4'd14) begin
            m_dir = w[15:4];
        end else if (a == 4'd15) begin
            m_out = w[15:4];
        end else if (w[7:4] == 4'b1101) begin
            m_ana = '0;
        end
    endfunction

    task automatic check_state(input string tag);
        check({tag, " codes"}, 128'(dac_code), 128'(flat_codes()));
        check({tag, " ana_en"}, 128'(ana_en), 128'(m_ana));
        check({tag, " pin_dir"}, 128'(pin_dir), 128'(m_dir));
        check({tag, " pin_out"}, 128'(pin_out), 128'(m_out));
    endtask

    // n ordinary edges, then optionally one edge coincident with the enable rise
    task automatic send_frame(input logic [15:0] w, input int n, input bit coinc, input string tag);
        logic [15:0] got, exp;
        int          bad_oe;
        bad_oe = 0;
        got = '0;
        exp = '0;
        ser_clk = 1'b0;
        ser_en  = 1'b0;
        for (int i = 0; i < n; i++) begin
            ser_din = (i < 16) ? w[15-i] : 1'b0;
            ser_clk = 1'b0;
            wait_cyc(H);
            if (ser_dout_oe !== 1'b1) bad_oe++;
            if (i < 16) begin
                got[15-i] = ser_dout;
                exp[15-i] = m_sr[15];
            end
            m_sr = {m_sr[14:0], ser_din};
            ser_clk = 1'b1;
            wait_cyc(H);
        end
        ser_clk = 1'b0;
        ser_din = (n < 16) ? w[15-n] : 1'b0;
        wait_cyc(H);
        if (coinc) ser_clk = 1'b1;
        ser_en = 1'b1;
        wait_cyc(H + 4);
        if (n <= 16) check({tag, " R9 dout replay"}, 128'(got), 128'(exp));
        check({tag, " R9 oe during frame"}, 128'(bad_oe), 128'(0));
        check({tag, " R9 oe idle"}, 128'(ser_dout_oe), 128'(0));
        if (n == 16) apply_word(m_sr);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd777);
        for (int i = 0; i < 12; i++) m_code[i] = '0;
        m_ana = '0; m_dir = '0; m_out = '0; m_sr = '0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        check_state("R1 reset");
        check("R1 oe reset", 128'(ser_dout_oe), 128'(0));

        send_frame(16'hF5A1, 16, 1'b0, "R4 A1 upper bits ignored");
        check_state("R4 R2 write ch0");
        send_frame(16'h03C6, 16, 1'b0, "R7 shared ch5");
        check_state("R7 shared sets ana");
        send_frame(16'h0B59, 16, 1'b0, "R7 shared ch8");
        send_frame(16'h0774, 16, 1'b0, "R7 dedicated ch3");
        check_state("R7 dedicated keeps ana");
        send_frame(16'hABD0, 16, 1'b0, "R6 hiz");
        check_state("R6 hiz clears ana keeps codes");
        send_frame(16'hFFC0, 16, 1'b0, "R6 other addr0");
        check_state("R6 other addr0 no effect");
        send_frame(16'h1232, 15, 1'b0, "R3 short");
        check_state("R3 15 edges discarded");
        send_frame(16'h4563, 17, 1'b0, "R3 long");
        check_state("R3 17 edges discarded");
        send_frame(16'hA5CE, 16, 1'b0, "R5 dir");
        send_frame(16'h3C3F, 16, 1'b0, "R5 out");
        check_state("R5 dir and out");
        pin_in = 12'hB2D;
        send_frame(16'h000D, 16, 1'b0, "R8 capture");
        pin_in = 12'h000;
        send_frame(16'h0000, 16, 1'b0, "R8 readout");
        check_state("R8 after capture");
        send_frame(16'h9E2C, 16, 1'b1, "R10 extra coincident edge");
        check_state("R10 frame accepted");
        send_frame(16'h7712, 15, 1'b1, "R10 sixteenth coincident");
        check_state("R10 frame discarded");

        for (int k = 0; k < 80; k++) begin
            logic [15:0] w;
            int r, n;
            w = 16'($urandom());
            r = int'($urandom() % 8);
            n = (r == 0) ? 15 : (r == 1) ? 17 : 16;
            if (r == 2) w[7:0] = 8'hD0;
            pin_in = 12'($urandom());
            send_frame(w, n, 1'b0, "R2 R4 random");
            check_state("R3 R4 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule